// File: doc/BRIEF.md
# Unaligned Word Load/Store Merge Unit

This block carries out the partial-word loads and stores of a little-endian 32-bit core. These are the loads and stores that move the upper or lower part of a word that starts at an unaligned address. It accepts one request at a time. A request carries an operation code, a byte address, a destination register index and the current register value. The block reads the word-aligned memory location. It then combines the bytes of that word with the bytes of the register value, and the low address bits select which bytes come from which source.

For a load, the merged value goes out on a register write port in the same cycle the read data returns. No memory write takes place. For a store, the block performs a read-modify-write. It reads the aligned word, merges it in a dedicated cycle, and writes the result back to the same aligned address.

The sequencer has four states:

- ST_IDLE: the block is ready and accepts a request.
- ST_READ: the read request is held until it is acknowledged.
- ST_MERGE: one cycle in which the store word is built.
- ST_WRITE: the write request is held until it is acknowledged.

The transitions are:

- ST_IDLE to ST_READ when a request is accepted.
- ST_READ to ST_IDLE on the acknowledge of a load.
- ST_READ to ST_MERGE on the acknowledge of a store.
- ST_MERGE to ST_WRITE unconditionally.
- ST_WRITE to ST_IDLE on the write acknowledge.

Top module: `lrmerge_top`

## Requirements
- R1: `req_op` encodes 00 = load-upper, 01 = load-lower, 10 = store-upper, 11 = store-lower. A request is accepted when `req_valid` and `req_ready` are both high. `req_ready` is high only in ST_IDLE, so it is low while an operation is in progress.
- R2: Every memory access uses `req_addr` with its two low bits forced to zero. The byte offset k is `req_addr[1:0]`.
- R3: For load-upper with offset k = 0, 1, 2, 3, the register result is (mem << 24, 16, 8, 0) OR (reg AND 0x00FFFFFF, 0x0000FFFF, 0x000000FF, 0x00000000).
- R4: For load-lower with offset k = 0, 1, 2, 3, the register result is (mem >> 0, 8, 16, 24) OR (reg AND 0x00000000, 0xFF000000, 0xFFFF0000, 0xFFFFFF00).
- R5: For store-upper with offset k = 0, 1, 2, 3, the written word is (reg >> 24, 16, 8, 0) OR (mem AND 0xFFFFFF00, 0xFFFF0000, 0xFF000000, 0x00000000).
- R6: For store-lower with offset k = 0, 1, 2, 3, the written word is (reg << 0, 8, 16, 24) OR (mem AND 0x00000000, 0x000000FF, 0x0000FFFF, 0x00FFFFFF).
- R7: A store makes exactly one read, then exactly one write, both to the same aligned address. The write request starts after one cycle with no memory request.
- R8: A load makes exactly one read and no write, and it leaves memory unchanged. `rf_we` is high only in the cycle `mem_ack` returns the read data, and `rf_widx` then equals the request index. With index 0 the read still happens, but `rf_we` never rises.
- R9: `done` is high for exactly one cycle. That cycle is the one after the final acknowledged access: the read for a load, the write for a store.
- R10: While `mem_req` is high and not acknowledged, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold their values.
- R11: After reset, `req_ready` is high and `mem_req`, `rf_we` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted this cycle if valid |
| req_op | input | 2 | Operation code (R1) |
| req_addr | input | ADDR_W | Byte address |
| req_idx | input | IDX_W | Destination register index (loads) |
| req_reg | input | DATA_W | Current register value: merge source for loads, store data for stores |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_wdata | output | DATA_W | Merged word to write |
| mem_ack | input | 1 | Access accepted; read data valid on reads |
| mem_rdata | input | DATA_W | Read data, valid with mem_ack |
| rf_we | output | 1 | Register write enable |
| rf_widx | output | IDX_W | Register write index |
| rf_wdata | output | DATA_W | Merged load result |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with DATA_W = 32, IDX_W = 5 and ADDR_W = 6. With that address width, a 16-word memory model covers every aligned address the block can emit. The small width also allows a complete sweep of all four operations, all four byte offsets, several data patterns and two memory latencies (immediate and two wait states). Every byte-lane selection and every state transition is therefore covered, including the held request under stall and the suppressed register write for index zero.

// File: rtl/lrmerge_pkg.sv
package lrmerge_pkg;

    typedef enum logic [1:0] {
        OP_LD_UPPER = 2'b00,
        OP_LD_LOWER = 2'b01,
        OP_ST_UPPER = 2'b10,
        OP_ST_LOWER = 2'b11
    } merge_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_MERGE,
        ST_WRITE
    } seq_state_e;

endpackage

// File: rtl/lrmerge_load_merge.sv
// Byte-lane selection for partial loads: each destination lane takes either
// a memory byte (shifted by the offset) or keeps the register byte.
module lrmerge_load_merge #(
    parameter  int DATA_W = 32,
    localparam int LANES  = DATA_W / 8,
    localparam int OFF_W  = $clog2(LANES)
) (
    input  logic              lower,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] mem_word,
    input  logic [DATA_W-1:0] reg_word,
    output logic [DATA_W-1:0] merged
);
    logic [7:0] mem_b [LANES];
    logic [7:0] reg_b [LANES];

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        assign mem_b[j] = mem_word[8*j +: 8];
        assign reg_b[j] = reg_word[8*j +: 8];

        always_comb begin
            int               ofs;
            int               shift_up;
            logic [OFF_W-1:0] sel;
            ofs      = int'(off);
            shift_up = LANES - 1 - ofs;
            if (!lower) begin
                sel = OFF_W'(j - shift_up);
                merged[8*j +: 8] = (j >= shift_up) ? mem_b[sel] : reg_b[j];
            end else begin
                sel = OFF_W'(j + ofs);
                merged[8*j +: 8] = (j < LANES - ofs) ? mem_b[sel] : reg_b[j];
            end
        end
    end
endmodule

// File: rtl/lrmerge_store_merge.sv
// Byte-lane selection for partial stores: each memory lane takes either a
// register byte (shifted by the offset) or keeps the memory byte.
module lrmerge_store_merge #(
    parameter  int DATA_W = 32,
    localparam int LANES  = DATA_W / 8,
    localparam int OFF_W  = $clog2(LANES)
) (
    input  logic              lower,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] mem_word,
    input  logic [DATA_W-1:0] reg_word,
    output logic [DATA_W-1:0] merged
);
    logic [7:0] mem_b [LANES];
    logic [7:0] reg_b [LANES];

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        assign mem_b[j] = mem_word[8*j +: 8];
        assign reg_b[j] = reg_word[8*j +: 8];

        always_comb begin
            int               ofs;
            logic [OFF_W-1:0] sel;
            ofs = int'(off);
            if (!lower) begin
                sel = OFF_W'(j + LANES - 1 - ofs);
                merged[8*j +: 8] = (j <= ofs) ? reg_b[sel] : mem_b[j];
            end else begin
                sel = OFF_W'(j - ofs);
                merged[8*j +: 8] = (j >= ofs) ? reg_b[sel] : mem_b[j];
            end
        end
    end
endmodule

// File: rtl/lrmerge_seq.sv
module lrmerge_seq
    import lrmerge_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_store,
    input  logic mem_ack,
    output logic req_ready,
    output logic accept,
    output logic mem_req,
    output logic mem_we,
    output logic rd_done,
    output logic merge_en,
    output logic done
);
    seq_state_e state_q, state_d;
    logic       store_q;
    logic       finish;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_READ;
            ST_READ:  if (mem_ack)   state_d = store_q ? ST_MERGE : ST_IDLE;
            ST_MERGE:                state_d = ST_WRITE;
            ST_WRITE: if (mem_ack)   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            store_q <= 1'b0;
            done    <= 1'b0;
        end else begin
            state_q <= state_d;
            done    <= finish;
            if (accept) store_q <= req_store;
        end
    end

    always_comb begin
        req_ready = 1'b0;
        accept    = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        rd_done   = 1'b0;
        merge_en  = 1'b0;
        finish    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                accept    = req_valid;
            end
            ST_READ: begin
                mem_req = 1'b1;
                rd_done = mem_ack;
                finish  = mem_ack && !store_q;
            end
            ST_MERGE: merge_en = 1'b1;
            ST_WRITE: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                finish  = mem_ack;
            end
        endcase
    end
endmodule

// File: rtl/lrmerge_top.sv
module lrmerge_top
    import lrmerge_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [DATA_W-1:0] req_reg,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              rf_we,
    output logic [IDX_W-1:0]  rf_widx,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              done
);
    localparam int LANES = DATA_W / 8;
    localparam int OFF_W = $clog2(LANES);

    merge_op_e         op_q;
    logic [OFF_W-1:0]  off_q;
    logic [ADDR_W-1:0] addr_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] reg_q, rdata_q, wdata_q, st_merged;
    logic              accept, rd_done, merge_en;
    logic              op_store, op_lower;

    assign op_store = op_q[1];
    assign op_lower = op_q[0];

    lrmerge_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_store (req_op[1]),
        .mem_ack   (mem_ack),
        .req_ready (req_ready),
        .accept    (accept),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .rd_done   (rd_done),
        .merge_en  (merge_en),
        .done      (done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= OP_LD_UPPER;
            off_q   <= '0;
            addr_q  <= '0;
            idx_q   <= '0;
            reg_q   <= '0;
            rdata_q <= '0;
            wdata_q <= '0;
        end else begin
            if (accept) begin
                op_q   <= merge_op_e'(req_op);
                off_q  <= req_addr[OFF_W-1:0];
                addr_q <= {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
                idx_q  <= req_idx;
                reg_q  <= req_reg;
            end
            if (rd_done)  rdata_q <= mem_rdata;
            if (merge_en) wdata_q <= st_merged;
        end
    end

    lrmerge_load_merge #(.DATA_W(DATA_W)) u_ld (
        .lower    (op_lower),
        .off      (off_q),
        .mem_word (mem_rdata),
        .reg_word (reg_q),
        .merged   (rf_wdata)
    );

    lrmerge_store_merge #(.DATA_W(DATA_W)) u_st (
        .lower    (op_lower),
        .off      (off_q),
        .mem_word (rdata_q),
        .reg_word (reg_q),
        .merged   (st_merged)
    );

    assign mem_addr  = addr_q;
    assign mem_wdata = wdata_q;
    assign rf_we     = rd_done && !op_store && (idx_q != '0);
    assign rf_widx   = idx_q;
endmodule

// File: rtl/lrmerge_chk.sv
module lrmerge_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ack,
    input logic              rf_we,
    input logic [IDX_W-1:0]  rf_widx,
    input logic              done
);
    localparam int OFF_W = $clog2(DATA_W / 8);

    p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_req && !rf_we));

    p_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[OFF_W-1:0] == '0));

    p_gap_before_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req && mem_we) |-> $past(!mem_req));

    p_rfwe_on_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (mem_req && mem_ack && !mem_we && rf_widx != '0));

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_req && mem_ack));

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we)
                                   && $stable(mem_addr) && $stable(mem_wdata)));
endmodule

bind lrmerge_top lrmerge_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .rf_we     (rf_we),
    .rf_widx   (rf_widx),
    .done      (done)
);

// File: tb/lrmerge_top_tb.sv
module lrmerge_top_tb;
    localparam int DW = 32;
    localparam int AW = 6;
    localparam int IW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [IW-1:0] req_idx = '0;
    logic [DW-1:0] req_reg = '0;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_ack;
    logic [DW-1:0] mem_rdata;
    logic          rf_we;
    logic [IW-1:0] rf_widx;
    logic [DW-1:0] rf_wdata;
    logic          done;

    always #4 clk = ~clk;

    lrmerge_top #(.DATA_W(DW), .ADDR_W(AW), .IDX_W(IW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_idx(req_idx), .req_reg(req_reg),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .rf_we(rf_we), .rf_widx(rf_widx),
        .rf_wdata(rf_wdata), .done(done)
    );

    // Memory model: acknowledges after lat wait cycles.
    logic [31:0] mem [16];
    int lat = 0, cnt = 0, nrd = 0, nwr = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
            cnt = 0;
        end else if (mem_req && !mem_ack) begin
            if (cnt >= lat) begin
                mem_ack   <= 1'b1;
                mem_rdata <= mem[mem_addr[5:2]];
                cnt = 0;
                if (mem_we) begin
                    mem[mem_addr[5:2]] = mem_wdata;
                    nwr++;
                end else begin
                    nrd++;
                end
            end else begin
                cnt++;
            end
        end else begin
            mem_ack <= 1'b0;
            cnt = 0;
        end
    end

    // Output monitor, away from the active edge.
    int done_cnt = 0, rf_cnt = 0, addr_bad = 0, rfwe_bad = 0;
    logic [31:0]   rf_last;
    logic [IW-1:0] rf_idx_last;
    logic [AW-1:0] exp_addr = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) done_cnt++;
            if (rf_we) begin
                rf_cnt++;
                rf_last     = rf_wdata;
                rf_idx_last = rf_widx;
                if (!mem_ack) rfwe_bad++;
            end
            if (mem_req && mem_addr != exp_addr) addr_bad++;
        end
    end

    int nchk = 0, nfail = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    function automatic logic [31:0] exp_val(input logic [1:0] op, input int k,
                                            input logic [31:0] m, input logic [31:0] r);
        logic [31:0] v;
        v = '0;
        case (op)
            2'b00: case (k)
                0: v = (m << 24) | (r & 32'h00FFFFFF);
                1: v = (m << 16) | (r & 32'h0000FFFF);
                2: v = (m << 8)  | (r & 32'h000000FF);
                default: v = m;
            endcase
            2'b01: case (k)
                0: v = m;
                1: v = (m >> 8)  | (r & 32'hFF000000);
                2: v = (m >> 16) | (r & 32'hFFFF0000);
                default: v = (m >> 24) | (r & 32'hFFFFFF00);
            endcase
            2'b10: case (k)
                0: v = (r >> 24) | (m & 32'hFFFFFF00);
                1: v = (r >> 16) | (m & 32'hFFFF0000);
                2: v = (r >> 8)  | (m & 32'hFF000000);
                default: v = r;
            endcase
            default: case (k)
                0: v = r;
                1: v = (r << 8)  | (m & 32'h000000FF);
                2: v = (r << 16) | (m & 32'h0000FFFF);
                default: v = (r << 24) | (m & 32'h00FFFFFF);
            endcase
        endcase
        return v;
    endfunction

    task automatic run_op(input logic [1:0] op, input int w, input int k,
                          input logic [IW-1:0] idx, input logic [31:0] mval,
                          input logic [31:0] rval);
        int d0, f0, a0, b0, r0, w0, t;
        logic [31:0] expv;
        string rq;
        case (op)
            2'b00:   rq = "R3";
            2'b01:   rq = "R4";
            2'b10:   rq = "R5";
            default: rq = "R6";
        endcase
        mem[w]     = mval;
        mem[w ^ 1] = ~mval;
        exp_addr   = AW'(w * 4);
        d0 = done_cnt; f0 = rf_cnt; a0 = addr_bad; b0 = rfwe_bad; r0 = nrd; w0 = nwr;
        req_valid = 1'b1;
        req_op    = op;
        req_addr  = AW'(w * 4 + k);
        req_idx   = idx;
        req_reg   = rval;
        step();
        req_valid = 1'b0;
        chk(!req_ready, "R1 ready low while busy", 32'(req_ready), 0);
        t = 0;
        while (done_cnt == d0 && t < 100) begin
            step();
            t++;
        end
        if (t >= 100) chk(0, "R9 watchdog waiting for done", 32'(t), 100);
        step();
        expv = exp_val(op, k, mval, rval);
        chk(done_cnt - d0 == 1, "R9 single done pulse", 32'(done_cnt - d0), 1);
        chk(addr_bad == a0, "R2 aligned address", 32'(addr_bad - a0), 0);
        if (op[1]) begin
            chk(mem[w] == expv, rq, mem[w], expv);
            chk(mem[w ^ 1] == ~mval, "R7 neighbour word untouched", mem[w ^ 1], ~mval);
            chk(nrd - r0 == 1 && nwr - w0 == 1, "R7 one read then one write (R10 under stall)",
                32'((nrd - r0) * 16 + (nwr - w0)), 32'h11);
            chk(rf_cnt == f0, "R8 no register write on store", 32'(rf_cnt - f0), 0);
        end else begin
            chk(nrd - r0 == 1 && nwr - w0 == 0, "R8 load: one read, no write (R10 under stall)",
                32'((nrd - r0) * 16 + (nwr - w0)), 32'h10);
            chk(mem[w] == mval, "R8 memory unchanged by load", mem[w], mval);
            chk(rfwe_bad == b0, "R8 rf_we only with read data", 32'(rfwe_bad - b0), 0);
            if (idx == '0) begin
                chk(rf_cnt == f0, "R8 index zero suppresses write", 32'(rf_cnt - f0), 0);
            end else begin
                chk(rf_cnt - f0 == 1, "R8 one register write", 32'(rf_cnt - f0), 1);
                chk(rf_last == expv, rq, rf_last, expv);
                chk(rf_idx_last == idx, "R8 write index", 32'(rf_idx_last), 32'(idx));
            end
        end
    endtask

    initial begin
        #(8 * 150000);
        nfail++;
        $display("FAIL watchdog R9 actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        logic [31:0] mp [3];
        logic [31:0] rp [3];
        mp[0] = 32'h11223344; rp[0] = 32'hAABBCCDD;
        mp[1] = 32'hFFFFFFFF; rp[1] = 32'h00000000;
        mp[2] = 32'h80C0E0F0; rp[2] = 32'h0F0E0D0C;
        for (int i = 0; i < 16; i++) mem[i] = 32'(i) * 32'h01010101;
        step();
        step();
        chk(req_ready && !mem_req && !rf_we && !done, "R11 reset state",
            {28'h0, req_ready, mem_req, rf_we, done}, 32'h8);
        rst_n = 1'b1;
        step();
        chk(req_ready && !mem_req && !rf_we && !done, "R11 idle after reset",
            {28'h0, req_ready, mem_req, rf_we, done}, 32'h8);
        for (int l = 0; l < 2; l++) begin
            lat = l * 2;
            for (int p = 0; p < 3; p++)
                for (int o = 0; o < 4; o++)
                    for (int k = 0; k < 4; k++)
                        run_op(2'(o), (p * 4 + k + o + l) % 16, k, IW'(k + 1 + o),
                               mp[p] ^ 32'(l), rp[p]);
        end
        // R8: loads to index zero still read but never write the register.
        for (int k = 0; k < 4; k++) begin
            run_op(2'b00, 3 + k, k, '0, 32'hDEADBEEF, 32'h12345678);
            run_op(2'b01, 7 + k, k, '0, 32'hCAFEF00D, 32'h87654321);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule